// File: doc/BRIEF.md
# Filtered Interrupt Aggregator

This block collects two active-low interrupt requests, one from each downstream channel of a bus switch, and turns them into a single active-low interrupt for the upstream host. Each request line is first brought into the system clock domain. It is then deglitched with two separate qualification windows. A fall to the asserted (low) level must persist for `LOW_QUAL` sampled cycles before it is believed. A return to the idle (high) level must persist for `HIGH_QUAL` sampled cycles. Requests are watched at all times, whichever channels the switch currently has connected.

The filtered levels feed two outputs. The first is the upstream interrupt line, which is driven low when either filtered request is asserted and is released only when both are idle. The second is an active-high two-bit status vector that a register read can sample. Bit 0 reports channel 0 and bit 1 reports channel 1.

The pin is open-drain. `irq_out_n` = 0 means the pull-down is on; `irq_out_n` = 1 means the pin is left floating for an external pull-up. All timing is given in system-clock cycles. At 250 MHz the defaults are `LOW_QUAL` = 250 (1 µs) and `HIGH_QUAL` = 125 (0.5 µs). Assertion latency is 253 cycles (about 1.01 µs), which is inside the 4 µs bound. Release latency is 128 cycles (about 0.51 µs), which is inside the 2 µs bound.

Top module: `irq_aggregator`

## Requirements
- R1: While and after synchronous reset, with no request yet qualified, `irq_out_n` is 1 (released) and `irq_status` is 2'b00.
- R2: A request line held low for fewer than `LOW_QUAL` consecutive sampled cycles is rejected. A line held low for `LOW_QUAL` or more consecutive sampled cycles is accepted as asserted.
- R3: Once a line is accepted as asserted, a return high lasting fewer than `HIGH_QUAL` consecutive sampled cycles is rejected. A high level lasting `HIGH_QUAL` or more consecutive sampled cycles is accepted as idle.
- R4: `irq_out_n` is 0 whenever at least one filtered request is asserted. It is 1 only when both filtered requests are idle, which is a wired-AND of the active-low lines.
- R5: `irq_status[i]` is 1 exactly when filtered request `i` is asserted. Bit 0 belongs to `irq_in_n[0]` and bit 1 belongs to `irq_in_n[1]`.
- R6: After an input edge that is then held, the outputs change exactly Q+3 clock edges later. Q is `LOW_QUAL` for a fall and `HIGH_QUAL` for a rise. The three extra edges are two synchronizer stages and one output register.
- R7: Each line is filtered by its own counter. Activity on one line never changes the qualification or the status bit of the other line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in_n | input | 2 | Raw active-low interrupt requests, one per downstream channel, asynchronous |
| irq_out_n | output | 1 | Open-drain interrupt level: 0 = pull low, 1 = release |
| irq_status | output | 2 | Active-high filtered request levels for register read-back |

## Verification
On every cycle, the assertions check four things. The per-line counter stays below its qualify bound. A filtered level falls only after exactly `LOW_QUAL` and rises only after exactly `HIGH_QUAL` matching samples. The output line agrees with the status vector as a wired-AND. Other behaviour can only be shown by the bench's scenarios against its cycle-level model. This covers rejection of pulses one cycle short of a window, the exact Q+3 output latency, the independence of the two lines under random overlapping activity, and the reset state.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned NUM_CH          = 2;
    localparam int unsigned DEF_LOW_QUAL    = 250;
    localparam int unsigned DEF_HIGH_QUAL   = 125;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic {
        LVL_ASSERTED = 1'b0,
        LVL_IDLE     = 1'b1
    } irq_lvl_e;

    function automatic int unsigned qual_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned qual_cnt_width(input int unsigned a, input int unsigned b);
        return $clog2(qual_max(a, b) + 1);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= '1;
        end else begin
            pipe_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/irq_deglitch.sv
module irq_deglitch
    import irq_agg_pkg::*;
#(
    parameter int unsigned LOW_QUAL  = DEF_LOW_QUAL,
    parameter int unsigned HIGH_QUAL = DEF_HIGH_QUAL
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     smp_i,
    output irq_lvl_e lvl_o
);
    localparam int unsigned CW = qual_cnt_width(LOW_QUAL, HIGH_QUAL);
    localparam logic [CW-1:0] LOW_T  = CW'(LOW_QUAL);
    localparam logic [CW-1:0] HIGH_T = CW'(HIGH_QUAL);
    localparam logic [CW-1:0] MAX_T  = CW'(qual_max(LOW_QUAL, HIGH_QUAL));

    irq_lvl_e      lvl_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target;
    logic [CW-1:0] cnt_inc;
    logic          differs;

    always_comb begin
        differs = (smp_i != logic'(lvl_q));
        target  = smp_i ? HIGH_T : LOW_T;
        cnt_inc = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= LVL_IDLE;
            cnt_q <= '0;
        end else if (!differs) begin
            cnt_q <= '0;
        end else if (cnt_inc == target) begin
            lvl_q <= irq_lvl_e'(smp_i);
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc;
        end
    end

    assign lvl_o = lvl_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < MAX_T); // R6
    AST_LOW_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (lvl_q == LVL_IDLE && smp_i == 1'b0 && cnt_inc == LOW_T) |=> (lvl_q == LVL_ASSERTED)); // R2
    AST_LOW_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (lvl_q == LVL_IDLE && cnt_inc != LOW_T) |=> (lvl_q == LVL_IDLE)); // R2
    AST_HIGH_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (lvl_q == LVL_ASSERTED && cnt_inc != HIGH_T) |=> (lvl_q == LVL_ASSERTED)); // R3
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned LOW_QUAL    = DEF_LOW_QUAL,
    parameter int unsigned HIGH_QUAL   = DEF_HIGH_QUAL,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] irq_in_n,
    output logic              irq_out_n,
    output logic [NUM_CH-1:0] irq_status
);
    logic [NUM_CH-1:0] smp;
    logic [NUM_CH-1:0] flt_n;
    logic              line_q;
    logic [NUM_CH-1:0] stat_q;

    irq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(irq_in_n),
        .sync_o (smp)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        irq_lvl_e lvl;
        irq_deglitch #(.LOW_QUAL(LOW_QUAL), .HIGH_QUAL(HIGH_QUAL)) u_flt (
            .clk  (clk),
            .rst  (rst),
            .smp_i(smp[ch]),
            .lvl_o(lvl)
        );
        assign flt_n[ch] = logic'(lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b1;
            stat_q <= '0;
        end else begin
            line_q <= &flt_n;
            stat_q <= ~flt_n;
        end
    end

    assign irq_out_n  = line_q;
    assign irq_status = stat_q;

    AST_WIRED_AND: assert property (@(posedge clk) disable iff (rst)
        irq_out_n == (irq_status == '0)); // R4
    AST_RELEASE_NEEDS_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!irq_out_n && !(&flt_n)) |=> !irq_out_n); // R4
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (irq_out_n && irq_status == '0)); // R1
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    localparam int LQ = 250;
    localparam int HQ = 125;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] irq_in_n = 2'b11;
    logic       irq_out_n;
    logic [1:0] irq_status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_en = 0;

    always #2 clk = ~clk;

    irq_aggregator #(.LOW_QUAL(LQ), .HIGH_QUAL(HQ)) uut (
        .clk(clk), .rst(rst), .irq_in_n(irq_in_n),
        .irq_out_n(irq_out_n), .irq_status(irq_status)
    );

    // Spec model: 2 sync edges, a run-length window per line, 1 output edge.
    logic [1:0] m1, m2, mf;
    int         run [2];
    logic       mo;
    logic [1:0] ms;

    function automatic int need_len(input logic toward);
        return toward ? HQ : LQ;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m1 <= 2'b11; m2 <= 2'b11; mf <= 2'b11;
            run[0] <= 0; run[1] <= 0;
            mo <= 1'b1; ms <= 2'b00;
        end else begin
            m1 <= irq_in_n;
            m2 <= m1;
            for (int i = 0; i < 2; i++) begin
                if (m2[i] == mf[i]) run[i] <= 0;
                else if (run[i] + 1 >= need_len(m2[i])) begin
                    mf[i] <= m2[i]; run[i] <= 0;
                end else run[i] <= run[i] + 1;
            end
            mo <= &mf;
            ms <= ~mf;
        end
    end

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk("R4 line vs model", {1'b0, irq_out_n}, {1'b0, mo});
            chk("R5 R7 status vs model", irq_status, ms);
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        hold(4);
        chk("R1 reset line", {1'b0, irq_out_n}, 2'b01);
        chk("R1 reset status", irq_status, 2'b00);
        rst = 1'b0;
        hold(3);
        chk("R1 after reset line", {1'b0, irq_out_n}, 2'b01);
        cmp_en = 1;

        // R2: low pulse one short of window rejected
        irq_in_n[0] = 1'b0; hold(LQ - 1);
        irq_in_n[0] = 1'b1; hold(LQ + 10);
        chk("R2 short low rejected", {irq_out_n, irq_status}, 3'b100);

        // R2 R6: exact window accepted, latency LQ+3
        irq_in_n[0] = 1'b0; hold(LQ + 2);
        chk("R6 line before fall latency", {1'b0, irq_out_n}, 2'b01);
        hold(1);
        chk("R2 R6 line at fall latency", {1'b0, irq_out_n}, 2'b00);
        chk("R5 status bit0", irq_status, 2'b01);
        irq_in_n[0] = 1'b1; hold(3);
        irq_in_n[0] = 1'b0; hold(HQ + 10);
        chk("R2 exact LQ low keeps asserted", irq_status, 2'b01);

        // R3: high glitch one short rejected
        irq_in_n[0] = 1'b1; hold(HQ - 1);
        irq_in_n[0] = 1'b0; hold(HQ + 10);
        chk("R3 short high rejected", {1'b0, irq_out_n}, 2'b00);

        // R7 R4: channel 1 asserts too; channel 0 releases, line stays low
        irq_in_n[1] = 1'b0; hold(LQ + 5);
        chk("R5 both status", irq_status, 2'b11);
        irq_in_n[0] = 1'b1; hold(HQ + 2);
        chk("R6 before rise latency", irq_status, 2'b11);
        hold(1);
        chk("R6 R7 ch0 released at HQ+3", irq_status, 2'b10);
        chk("R4 line low while ch1 asserted", {1'b0, irq_out_n}, 2'b00);
        irq_in_n[1] = 1'b1; hold(HQ + 3);
        chk("R4 line released when both idle", {irq_out_n, irq_status}, 3'b100);

        // R7: glitching line 1 leaves line 0 untouched
        irq_in_n[0] = 1'b0; hold(LQ + 5);
        for (int k = 0; k < 20; k++) begin
            irq_in_n[1] = ~irq_in_n[1]; hold(3);
        end
        irq_in_n[1] = 1'b1; hold(HQ + 5);
        chk("R7 ch1 glitches ignored", irq_status, 2'b01);
        irq_in_n = 2'b11; hold(HQ + 5);

        // Random segments near the window edges
        for (int seg = 0; seg < 120; seg++) begin
            int d;
            irq_in_n[0] = 1'($urandom_range(0, 1));
            irq_in_n[1] = 1'($urandom_range(0, 1));
            d = $urandom_range(0, 3) == 0 ? $urandom_range(LQ - 3, LQ + 3)
                                          : $urandom_range(1, HQ + 3);
            hold(d);
        end
        irq_in_n = 2'b11; hold(LQ + 10);
        chk("R3 random run ends idle", {irq_out_n, irq_status}, 3'b100);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule